// File: doc/BRIEF.md
# Static Branch Direction Predictor

This unit guesses whether a conditional branch will be taken, using only facts visible at decode time and never any recorded runtime history. For each decoded branch it receives a valid flag, a flag for unconditional transfers and calls, a per-instruction compiler hint bit, and the signed branch displacement. A mode input selects one of three fixed policies: always predict not taken, follow the compiler hint, or predict backward branches taken and forward branches not taken. The prediction is registered and appears one clock after the branch is presented.

When the branch later executes, the pipeline reports the actual outcome together with the prediction that was issued for it on a resolve port. The unit then counts resolved branches and correct predictions in two saturating counters. Changing the mode clears both counters, so each policy's accuracy can be measured on its own over a stretch of code and compared with the others.

Top module: `static_bp`

## Requirements
- R1: While reset is high and in the first cycle after it, pred_valid is 0, pred_taken is 0, and both counters read 0.
- R2: Mode 2'b00 (biased) and the reserved mode 2'b11 predict every conditional branch not taken (pred_taken = 0).
- R3: Mode 2'b01 (hint) predicts taken when br_hint is 1 and not taken when br_hint is 0.
- R4: Mode 2'b10 (offset) predicts taken when the displacement's top bit is 1 (negative, backward branch); a zero or positive displacement predicts not taken.
- R5: When br_uncond is 1, the prediction is taken in every mode, whatever the hint and displacement.
- R6: The prediction appears on pred_valid/pred_taken exactly one clock after br_valid is sampled high; a cycle with br_valid low gives pred_valid = 0 and pred_taken = 0. Identical inputs always give the identical prediction.
- R7: Each cycle with res_valid high adds 1 to total_cnt, and adds 1 to correct_cnt when res_taken equals res_pred; the new values are visible one clock later.
- R8: Each counter stops at its all-ones value (255 with CNT_W = 8) and does not wrap.
- R9: In a cycle where mode differs from the mode of the previous cycle, both counters are cleared to 0 and any resolve reported in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Policy select: 00 biased, 01 hint, 10 offset, 11 treated as biased |
| br_valid | input | 1 | A decoded branch is presented this cycle |
| br_uncond | input | 1 | The branch is unconditional or a call |
| br_hint | input | 1 | Compiler hint bit, 1 means likely taken |
| br_disp | input | DISP_W | Signed branch displacement |
| pred_valid | output | 1 | Registered: a prediction is present |
| pred_taken | output | 1 | Registered predicted direction, 1 = taken |
| res_valid | input | 1 | A branch outcome is reported this cycle |
| res_taken | input | 1 | Actual outcome of the resolved branch |
| res_pred | input | 1 | Prediction that was issued for the resolved branch |
| total_cnt | output | CNT_W | Saturating count of resolved branches |
| correct_cnt | output | CNT_W | Saturating count of correct predictions |

## Verification
The direction logic is driven with a table that crosses every mode with hint values, negative, zero, positive and extreme displacements, and the unconditional flag, so a wrong policy, a swapped hint polarity, a misplaced sign bit or a zero treated as backward each produce a distinct miscompare. Gaps with br_valid low show whether the prediction is cleared rather than held. Resolve streams mixing matching and mismatching outcomes separate the two counters, a long run past 255 distinguishes saturation from wrap-around, and a mode change coinciding with a resolve shows that the clear wins over the count.

// File: rtl/static_bp_pkg.sv
package static_bp_pkg;
  typedef enum logic [1:0] {
    POL_BIASED = 2'b00,
    POL_HINT   = 2'b01,
    POL_OFFSET = 2'b10,
    POL_RSVD   = 2'b11
  } policy_e;
endpackage

// File: rtl/sbp_policy.sv
module sbp_policy #(
  parameter int DISP_W = 16
) (
  input  static_bp_pkg::policy_e mode,
  input  logic                   uncond,
  input  logic                   hint,
  input  logic [DISP_W-1:0]      disp,
  output logic                   taken
);
  import static_bp_pkg::*;

  localparam int SIGN_BIT = DISP_W - 1;

  logic backward;
  assign backward = disp[SIGN_BIT];

  always_comb begin
    unique case (mode)
      POL_HINT:   taken = hint;
      POL_OFFSET: taken = backward;
      default:    taken = 1'b0;
    endcase
    if (uncond) taken = 1'b1;
  end
endmodule

// File: rtl/sbp_acc.sv
module sbp_acc #(
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  static_bp_pkg::policy_e mode,
  input  logic                   res_valid,
  input  logic                   res_hit,
  output logic [CNT_W-1:0]       total_cnt,
  output logic [CNT_W-1:0]       correct_cnt
);
  import static_bp_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  policy_e mode_q;
  logic    mode_chg;
  assign mode_chg = (mode != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= mode;
      total_cnt   <= '0;
      correct_cnt <= '0;
    end else begin
      mode_q <= mode;
      if (mode_chg) begin
        total_cnt   <= '0;
        correct_cnt <= '0;
      end else if (res_valid) begin
        if (total_cnt != CNT_MAX) total_cnt <= total_cnt + 1'b1;
        if (res_hit && correct_cnt != CNT_MAX) correct_cnt <= correct_cnt + 1'b1;
      end
    end
  end

  p_corr_le_total_r7: assert property (@(posedge clk) disable iff (rst)
    correct_cnt <= total_cnt);

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (total_cnt == CNT_MAX && res_valid && !mode_chg) |=> total_cnt == CNT_MAX);

  p_clear_on_mode_r9: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (total_cnt == '0 && correct_cnt == '0));

  p_miss_keeps_correct_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit && !mode_chg) |=> $stable(correct_cnt));
endmodule

// File: rtl/static_bp.sv
module static_bp #(
  parameter int DISP_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              br_valid,
  input  logic              br_uncond,
  input  logic              br_hint,
  input  logic [DISP_W-1:0] br_disp,
  output logic              pred_valid,
  output logic              pred_taken,
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic              res_pred,
  output logic [CNT_W-1:0]  total_cnt,
  output logic [CNT_W-1:0]  correct_cnt
);
  import static_bp_pkg::*;

  policy_e pol;
  logic    guess;
  assign pol = policy_e'(mode);

  sbp_policy #(.DISP_W(DISP_W)) u_pol (
    .mode   (pol),
    .uncond (br_uncond),
    .hint   (br_hint),
    .disp   (br_disp),
    .taken  (guess)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
    end else begin
      pred_valid <= br_valid;
      pred_taken <= br_valid & guess;
    end
  end

  sbp_acc #(.CNT_W(CNT_W)) u_acc (
    .clk         (clk),
    .rst         (rst),
    .mode        (pol),
    .res_valid   (res_valid),
    .res_hit     (res_taken == res_pred),
    .total_cnt   (total_cnt),
    .correct_cnt (correct_cnt)
  );

  p_biased_nt_r2: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !br_uncond && (mode == 2'b00 || mode == 2'b11)) |=> (pred_valid && !pred_taken));

  p_hint_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !br_uncond && mode == 2'b01) |=> (pred_taken == $past(br_hint)));

  p_offset_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !br_uncond && mode == 2'b10) |=> (pred_taken == $past(br_disp[DISP_W-1])));

  p_uncond_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_uncond) |=> (pred_valid && pred_taken));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !br_valid |=> (!pred_valid && !pred_taken));
endmodule

// File: tb/sim_static_bp.sv
module sim_static_bp;
  localparam int DISP_W = 16;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        mode = 2'b00;
  logic              br_valid = 1'b0, br_uncond = 1'b0, br_hint = 1'b0;
  logic [DISP_W-1:0] br_disp = '0;
  logic              pred_valid, pred_taken;
  logic              res_valid = 1'b0, res_taken = 1'b0, res_pred = 1'b0;
  logic [CNT_W-1:0]  total_cnt, correct_cnt;

  always #2.5 clk = ~clk;

  static_bp #(.DISP_W(DISP_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .mode(mode),
    .br_valid(br_valid), .br_uncond(br_uncond), .br_hint(br_hint), .br_disp(br_disp),
    .pred_valid(pred_valid), .pred_taken(pred_taken),
    .res_valid(res_valid), .res_taken(res_taken), .res_pred(res_pred),
    .total_cnt(total_cnt), .correct_cnt(correct_cnt)
  );

  // vector: {mode[1:0], uncond, hint, disp[15:0], expected taken}
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b1, 16'hFFF0, 1'b0},  // R2 biased ignores hint and sign
    {2'b00, 1'b0, 1'b0, 16'h0040, 1'b0},  // R2
    {2'b11, 1'b0, 1'b1, 16'h8000, 1'b0},  // R2 reserved mode acts biased
    {2'b00, 1'b1, 1'b0, 16'h0010, 1'b1},  // R5 unconditional
    {2'b01, 1'b0, 1'b1, 16'h0020, 1'b1},  // R3 hint set, forward
    {2'b01, 1'b0, 1'b0, 16'hFF00, 1'b0},  // R3 hint clear, backward
    {2'b01, 1'b0, 1'b1, 16'hFF00, 1'b1},  // R3
    {2'b01, 1'b1, 1'b0, 16'h0004, 1'b1},  // R5
    {2'b10, 1'b0, 1'b0, 16'hFFFC, 1'b1},  // R4 backward
    {2'b10, 1'b0, 1'b1, 16'h0008, 1'b0},  // R4 forward, hint ignored
    {2'b10, 1'b0, 1'b0, 16'h0000, 1'b0},  // R4 zero is forward
    {2'b10, 1'b0, 1'b0, 16'h8000, 1'b1},  // R4 most negative
    {2'b10, 1'b0, 1'b0, 16'h7FFF, 1'b0},  // R4 most positive
    {2'b10, 1'b1, 1'b0, 16'h0100, 1'b1},  // R5
    {2'b11, 1'b1, 1'b0, 16'hFFFF, 1'b1},  // R5
    {2'b10, 1'b0, 1'b0, 16'hFFFC, 1'b1}   // R6 repeat gives same answer
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic resolve(input logic t, input logic p);
    res_valid = 1'b1; res_taken = t; res_pred = p;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 pred_valid in reset", pred_valid, 0);
    chk("R1 total in reset", total_cnt, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pred_valid after reset", pred_valid, 0);
    chk("R1 pred_taken after reset", pred_taken, 0);
    chk("R1 correct after reset", correct_cnt, 0);

    for (int i = 0; i < NV; i++) begin
      {mode, br_uncond, br_hint, br_disp} = VEC[i][20:1];
      br_valid = 1'b1;
      @(negedge clk);
      chk("R6 pred_valid", pred_valid, 1);
      chk($sformatf("R2/R3/R4/R5 vector %0d", i), pred_taken, VEC[i][0]);
    end

    // R6: idle cycle clears the prediction even with a taken-looking input
    br_uncond = 1'b1; br_valid = 1'b0;
    @(negedge clk);
    chk("R6 idle pred_valid", pred_valid, 0);
    chk("R6 idle pred_taken", pred_taken, 0);
    br_uncond = 1'b0;

    // counters: settle a new mode first (R9 clear)
    mode = 2'b01;
    @(negedge clk);
    chk("R9 clear after mode change", total_cnt, 0);
    resolve(1, 1); resolve(0, 1); resolve(0, 0); resolve(1, 0); resolve(1, 1);
    chk("R7 total", total_cnt, 5);
    chk("R7 correct", correct_cnt, 3);

    // R9: mode change in same cycle as resolve; clear wins
    mode = 2'b10;
    resolve(1, 1);
    chk("R9 total cleared", total_cnt, 0);
    chk("R9 correct cleared", correct_cnt, 0);
    resolve(1, 1);
    chk("R7 count resumes", total_cnt, 1);

    // R8 saturation
    for (int k = 0; k < 300; k++) resolve(0, 0);
    chk("R8 total saturates", total_cnt, 255);
    chk("R8 correct saturates", correct_cnt, 255);
    resolve(1, 0);
    chk("R8 total holds", total_cnt, 255);
    chk("R8 correct holds", correct_cnt, 255);

    // R1 reset clears counters again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 counters after second reset", total_cnt, 0);
    finish_run();
  end
endmodule